// File: doc/BRIEF.md
# I3C Target Write Data Word Receiver

This block sits in the target side of an I3C bus and turns the serial data words that a controller writes in SDR mode into bytes. Each word is nine bits long: eight data bits, most significant first, followed by a check bit that makes the word's count of ones odd. The block does not handle bus pins directly. It runs on a system clock and takes a one-cycle strobe that marks each rising SCL edge, together with the SDA level already synchronised to that clock.

Once nine rising edges have been collected, the block compares the check bit with the odd parity of the byte. A byte that passes is offered on a valid/ready output to a receive FIFO. A byte that fails is discarded and a sticky parity-error flag is set. The target has no acknowledge slot in a write word, so it cannot stall the controller. A byte that completes while the FIFO is not ready is therefore dropped, and a sticky overflow flag is set. A start or stop indication from the bus-condition logic restarts bit alignment at any point. Software clears each flag with a one-cycle clear pulse.

Top module: `i3cWrRx`

## Requirements
- R1: After reset, `outValid`, `parityErr` and `overflowErr` are all 0.
- R2: Data bits are taken from `sdaIn` on cycles where `sclRise` is 1, most significant bit first. On the ninth such cycle, if parity is good, `outValid` is 1 in that same cycle and `outData` holds the eight data bits.
- R3: The ninth bit is accepted when it equals the XNOR reduction of the eight data bits, which is the XOR of all data bits inverted. For data 0x96 the accepted ninth bit is 1, and for 0x07 it is 0.
- R4: When the ninth bit does not match, `outValid` stays 0 for that word and `parityErr` is 1 from the next cycle. The flag stays 1 through later good words until it is cleared.
- R5: When `outValid` is 1 while `outReady` is 0, the byte is lost and `overflowErr` is 1 from the next cycle. The flag stays 1 until it is cleared.
- R6: A one-cycle `clrParErr` or `clrOvf` pulse clears its flag on the next cycle. If a new error of the same kind occurs in the same cycle as the clear, the flag stays 1.
- R7: A `frameEvt` pulse discards any partly received word and makes the next `sclRise` the first data bit. `outValid` is never 1 in a cycle where `frameEvt` is 1.
- R8: Changes on `sdaIn` in cycles without `sclRise` have no effect on the received data, on `outValid` or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclRise | input | 1 | One-cycle strobe marking a rising SCL edge |
| sdaIn | input | 1 | Synchronised SDA level, sampled when `sclRise` is 1 |
| frameEvt | input | 1 | Start or stop seen on the bus; realigns the bit counter |
| clrParErr | input | 1 | Write-one-to-clear pulse for `parityErr` |
| clrOvf | input | 1 | Write-one-to-clear pulse for `overflowErr` |
| outData | output | 8 | Received byte |
| outValid | output | 1 | Byte offered to the receive FIFO |
| outReady | input | 1 | Receive FIFO can accept a byte |
| parityErr | output | 1 | Sticky parity-mismatch flag |
| overflowErr | output | 1 | Sticky receive-overflow flag |

## Verification
The hardest case to reach is a new error arriving in the same cycle as its clear pulse. The bench holds `clrParErr` high during the ninth rising edge of a word that carries a wrong check bit, and then expects the flag to remain set. A second hard case is a word cut short by a start or stop. The bench sends four bits, pulses `frameEvt`, and then sends a complete word; if the old bits were kept, that word would come out shifted.

// File: rtl/i3cWrRxPkg.sv
package i3cWrRxPkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shift;   // take sdaIn into the byte
    logic push;    // offer byte to the FIFO
    logic setPar;  // parity mismatch on completed word
    logic setOvf;  // byte offered while FIFO not ready
  } rxStrobeT;
endpackage

// File: rtl/i3cWrRxCtrl.sv
module i3cWrRxCtrl
  import i3cWrRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRise,
  input  logic     frameEvt,
  input  logic     parOk,
  input  logic     outReady,
  output rxStrobeT strb
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bitCnt;
  logic atCheckBit;
  logic wordDone;

  always_comb begin
    atCheckBit  = (bitCnt == LAST_IDX);
    wordDone    = sclRise && !frameEvt && atCheckBit;
    strb.shift  = sclRise && !frameEvt && !atCheckBit;
    strb.push   = wordDone && parOk;
    strb.setPar = wordDone && !parOk;
    strb.setOvf = wordDone && parOk && !outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     bitCnt <= '0;
    else if (frameEvt || wordDone) bitCnt <= '0;
    else if (strb.shift)           bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/i3cWrRxDatapath.sv
module i3cWrRxDatapath
  import i3cWrRxPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  rxStrobeT          strb,
  input  logic              clrParErr,
  input  logic              clrOvf,
  output logic              parOk,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              parityErr,
  output logic              overflowErr
);
  logic [DATA_W-1:0] shiftReg;
  logic expBit;

  generate
    if (ODD_PARITY) begin : g_odd
      assign expBit = ~(^shiftReg);
    end else begin : g_even
      assign expBit = ^shiftReg;
    end
  endgenerate

  assign parOk    = (sdaIn == expBit);
  assign outData  = shiftReg;
  assign outValid = strb.push;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.shift) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr   <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      parityErr   <= strb.setPar || (parityErr && !clrParErr);
      overflowErr <= strb.setOvf || (overflowErr && !clrOvf);
    end
  end
endmodule

// File: rtl/i3cWrRx.sv
module i3cWrRx
  import i3cWrRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sdaIn,
  input  logic              frameEvt,
  input  logic              clrParErr,
  input  logic              clrOvf,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              parityErr,
  output logic              overflowErr
);
  rxStrobeT strb;
  logic parOk;

  i3cWrRxCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .frameEvt(frameEvt),
    .parOk(parOk), .outReady(outReady), .strb(strb)
  );

  i3cWrRxDatapath #(.DATA_W(DATA_W), .ODD_PARITY(1'b1)) u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strb(strb),
    .clrParErr(clrParErr), .clrOvf(clrOvf), .parOk(parOk),
    .outData(outData), .outValid(outValid),
    .parityErr(parityErr), .overflowErr(overflowErr)
  );
endmodule

// File: rtl/i3cWrRxChk.sv
module i3cWrRxChk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic sclRise,
  input logic frameEvt,
  input logic clrParErr,
  input logic clrOvf,
  input logic outValid,
  input logic outReady,
  input logic parityErr,
  input logic overflowErr
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  logic [CNT_W-1:0] riseCnt;
  logic lastRise;

  // independent count of edges since frame start
  assign lastRise = sclRise && !frameEvt && (riseCnt == CNT_W'(DATA_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         riseCnt <= '0;
    else if (frameEvt) riseCnt <= '0;
    else if (sclRise)  riseCnt <= (riseCnt == CNT_W'(DATA_W)) ? '0 : riseCnt + 1'b1;
  end

  a_r2_push_on_ninth: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> lastRise);
  a_r7_no_push_at_frame: assert property (@(posedge clk) disable iff (!rstN)
    frameEvt |-> !outValid);
  a_r4_bad_parity_sets: assert property (@(posedge clk) disable iff (!rstN)
    (lastRise && !outValid) |=> parityErr);
  a_r4_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !clrParErr) |=> parityErr);
  a_r5_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> overflowErr);
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !clrOvf) |=> overflowErr);
  a_r6_parity_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrParErr && !(lastRise && !outValid)) |=> !parityErr);
  a_r6_overflow_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrOvf && !(outValid && !outReady)) |=> !overflowErr);
  a_r8_quiet_without_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!sclRise && !clrParErr && !clrOvf) |=> ($stable(parityErr) && $stable(overflowErr)));
endmodule

bind i3cWrRx i3cWrRxChk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/i3cWrRx_tb.sv
module i3cWrRx_tb;
  logic clk = 1'b0;
  logic rstN, sclRise, sdaIn, frameEvt, clrParErr, clrOvf, outReady;
  logic [7:0] outData;
  logic outValid, parityErr, overflowErr;
  int checks = 0, errors = 0;
  logic gotValid;
  logic [7:0] gotData;

  always #2.5 clk = ~clk;

  i3cWrRx #(.DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sdaIn(sdaIn), .frameEvt(frameEvt),
    .clrParErr(clrParErr), .clrOvf(clrOvf), .outData(outData), .outValid(outValid),
    .outReady(outReady), .parityErr(parityErr), .overflowErr(overflowErr)
  );

  function automatic logic oddBit(input logic [7:0] d);
    return ~(^d);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit: strobe for one cycle, capture outputs during it, then a gap cycle with sda toggled
  task automatic sendBit(input logic b, input logic clrP);
    @(negedge clk);
    sdaIn = b; sclRise = 1'b1; clrParErr = clrP;
    #1 gotValid = outValid; gotData = outData;
    @(negedge clk);
    sclRise = 1'b0; clrParErr = 1'b0; sdaIn = ~b;
  endtask

  task automatic sendWord(input logic [7:0] d, input logic p, input logic clrP);
    for (int i = 7; i >= 0; i--) sendBit(d[i], 1'b0);
    sendBit(p, clrP);
  endtask

  task automatic pulseClear(input logic p, input logic o);
    @(negedge clk); clrParErr = p; clrOvf = o;
    @(negedge clk); clrParErr = 1'b0; clrOvf = 1'b0;
  endtask

  task automatic testReset();
    check("R1 valid", outValid, 0);
    check("R1 parityErr", parityErr, 0);
    check("R1 overflowErr", overflowErr, 0);
  endtask

  task automatic testGoodWords();
    logic [7:0] pats [4] = '{8'h96, 8'h07, 8'h00, 8'hD4};
    check("R3 parity of 0x96", oddBit(8'h96), 1);
    check("R3 parity of 0x07", oddBit(8'h07), 0);
    foreach (pats[k]) begin
      sendWord(pats[k], oddBit(pats[k]), 1'b0);
      check("R2 valid", gotValid, 1);
      check("R2 data", gotData, pats[k]);
      check("R3 no parity error", parityErr, 0);
    end
  endtask

  task automatic testBadParity();
    sendWord(8'h96, 1'b0, 1'b0);
    check("R4 bad word not pushed", gotValid, 0);
    check("R4 flag set", parityErr, 1);
    sendWord(8'h3C, oddBit(8'h3C), 1'b0);
    check("R4 later word pushed", gotValid, 1);
    check("R4 flag sticky", parityErr, 1);
    pulseClear(1'b1, 1'b0);
    check("R6 parity cleared", parityErr, 0);
    // error in the same cycle as the clear
    sendWord(8'hA5, ~oddBit(8'hA5), 1'b1);
    check("R6 set beats clear", parityErr, 1);
    pulseClear(1'b1, 1'b0);
    check("R6 parity cleared again", parityErr, 0);
  endtask

  task automatic testOverflow();
    outReady = 1'b0;
    sendWord(8'h5A, oddBit(8'h5A), 1'b0);
    check("R5 valid while not ready", gotValid, 1);
    check("R5 overflow set", overflowErr, 1);
    outReady = 1'b1;
    sendWord(8'h11, oddBit(8'h11), 1'b0);
    check("R5 overflow sticky", overflowErr, 1);
    pulseClear(1'b0, 1'b1);
    check("R6 overflow cleared", overflowErr, 0);
  endtask

  task automatic testFrameRealign();
    for (int i = 0; i < 4; i++) sendBit(1'b1, 1'b0);
    @(negedge clk); frameEvt = 1'b1; sclRise = 1'b1; sdaIn = 1'b1;
    #1 check("R7 no push at frame", outValid, 0);
    @(negedge clk); frameEvt = 1'b0; sclRise = 1'b0;
    sendWord(8'h69, oddBit(8'h69), 1'b0);
    check("R7 aligned valid", gotValid, 1);
    check("R7 aligned data", gotData, 8'h69);
    check("R7 no parity error", parityErr, 0);
  endtask

  task automatic testIdleSda();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sdaIn = i[0];
      #1 check("R8 no valid without edge", outValid, 0);
    end
    check("R8 flags unchanged", {parityErr, overflowErr}, 0);
    sendWord(8'hC3, oddBit(8'hC3), 1'b0);
    check("R8 data unaffected", gotData, 8'hC3);
    check("R8 valid", gotValid, 1);
  endtask

  initial begin
    rstN = 1'b0; sclRise = 0; sdaIn = 0; frameEvt = 0;
    clrParErr = 0; clrOvf = 0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGoodWords();
    testBadParity();
    testOverflow();
    testFrameRealign();
    testIdleSda();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule